// File: doc/BRIEF.md
# Macro-op fusion detector for an RV64 decode stage

This block sits in an RV64 decode stage behind the compressed-instruction expander. Each cycle it receives a window of up to three consecutive instructions, already in canonical 32-bit form. Each slot carries a valid flag and a flag saying whether the instruction was originally 16 bits long. The window also carries the program counter of its first slot. The block looks for a small set of multi-instruction idioms and, one cycle later, presents one micro-op. That micro-op is either a fused operation with its merged immediates, or the first instruction passed through alone.

Four idioms are recognised:
- a far jump formed by an upper-immediate add to the PC followed by an indirect jump, in both the linking form and the non-linking (tail) form;
- a PC-relative doubleword load;
- a 32-bit zero extension built from a left and a right shift by 32;
- a word add-immediate followed by that zero extension.

The output reports the number of instructions consumed and their total byte length, so the fetch logic can advance the window. When the non-linking jump or the load form leaves the address temporary architecturally visible, the micro-op also carries that secondary register write. For a linking jump through x1 or x5 it raises a hint for the return-address stack.

Top module: `fuse_unit`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, uop_valid is 0.
- R2: One clock after a window is applied, uop_valid equals the slot 0 valid bit. A slot flagged 16-bit counts 2 bytes and any other slot counts 4. When no pattern applies, or a slot a pattern needs is invalid, the micro-op has kind 0, count 1, bytes equal to slot 0's length, and uop_insn equal to slot 0's instruction.
- R3: An AUIPC (opcode 0010111) with rd=X≠0, followed by a JALR (opcode 1100111, funct3 000) with rd=X and rs1=X, gives kind 1 and count 2. Its target is (PC0 + (imm20<<12) + sext(imm12)) with bit 0 cleared. Its link value is the JALR's PC plus that JALR's length. uop_rd is X, and there is no secondary write.
- R4: uop_ras_push is 1 only for kind 1 with X equal to 1 or 5.
- R5: An AUIPC with rd=X≠0, followed by a JALR with rd=0 and rs1=X, gives kind 2 with the same cleared target and uop_rd=0. It also gives a secondary write of PC0+(imm20<<12) into X, and no push.
- R6: An AUIPC with rd=X≠0, followed by an LD (opcode 0000011, funct3 011) with rs1=X and rd=Y, gives kind 3 with address PC0+(imm20<<12)+sext(imm12), bit 0 kept, and uop_rd=Y. The secondary write of the AUIPC value into X happens only when Y≠X.
- R7: SLLI r,r,32 followed by SRLI r,r,32 with r≠0 gives kind 4 and count 2, with uop_rd=uop_src=r. Both shifts use opcode 0010011, with funct3 001 and 101 respectively and imm field 0x020.
- R8: ADDIW r,r,n (opcode 0011011, funct3 000) with r≠0, followed by the R7 shift pair on the same r, gives kind 5 and count 3, with uop_imm=sext(n). This takes priority over R7.
- R9: uop_bytes is the sum of the consumed slots' lengths for any mix of 16-bit and 32-bit origins.
- R10: Any register mismatch, a shift amount other than 32, an arithmetic right shift, or an AUIPC with rd=0 yields the R2 single pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 3 | Per-slot valid, bit i for slot i |
| in_half | input | 3 | Per-slot flag: instruction came from a 16-bit encoding |
| in_insn | input | 96 | Canonical instructions, slot i at bits [32i+31:32i] |
| in_pc | input | 64 | PC of slot 0 |
| uop_valid | output | 1 | Micro-op present |
| uop_kind | output | 3 | 0 single, 1 far call, 2 far tail jump, 3 PC-relative load, 4 zero extend, 5 zero-extended word add |
| uop_count | output | 2 | Instructions consumed |
| uop_bytes | output | 4 | Bytes consumed |
| uop_rd | output | 5 | Primary destination register |
| uop_src | output | 5 | Source register (shift/add forms, single) |
| uop_target | output | 64 | Jump target or load address |
| uop_link | output | 64 | Return address for jump forms |
| uop_imm | output | 64 | Sign-extended add immediate (kind 5) |
| uop_tmp_we | output | 1 | Secondary write of the address temporary |
| uop_tmp_rd | output | 5 | Register of the secondary write |
| uop_tmp_val | output | 64 | Value of the secondary write |
| uop_ras_push | output | 1 | Return-stack push hint |
| uop_insn | output | 32 | Slot 0 instruction for pass-through |

## Verification
The assertions take for granted that the window is presented with its valid bits and that in_valid is driven to known values from reset onward. The consumed-count and byte-range properties also assume that a slot marked 16-bit really was expanded from a compressed form. The bench holds every input steady from one falling edge to the next. It drives only known values, including during reset, and builds every instruction from field-level encoders, so that the register fields and immediates in each window are exactly those the scenario intends.

// File: rtl/fuse_pkg.sv
// Shared definitions for the fusion detector: window size, micro-op kinds
// and the per-slot decoded summary. Assumes canonical 32-bit encodings.
package fuse_pkg;

    localparam int NSLOT = 3;

    typedef enum logic [2:0] {
        K_SINGLE = 3'd0,
        K_CALL   = 3'd1,
        K_TAIL   = 3'd2,
        K_PCLD   = 3'd3,
        K_ZEXT   = 3'd4,
        K_ADDWZ  = 3'd5
    } fuse_kind_e;

    typedef struct packed {
        logic        is_auipc;
        logic        is_jalr;
        logic        is_ld;
        logic        is_slli32;
        logic        is_srli32;
        logic        is_addiw;
        logic [4:0]  rd;
        logic [4:0]  rs1;
        logic [11:0] imm12;
        logic [19:0] imm20;
    } slot_info_t;

endpackage

// File: rtl/fuse_slot_dec.sv
// Classifies one canonical instruction into the opcode classes the
// fusion matcher cares about and extracts its register and immediate fields.
// Assumes the input is already expanded from any compressed form.
module fuse_slot_dec
    import fuse_pkg::*;
#(
    parameter int ILEN = 32
) (
    input  logic [ILEN-1:0] insn,
    output slot_info_t      info
);

    logic [6:0]  opc;
    logic [2:0]  f3;
    logic [11:0] hi12;

    // Field extraction and class decode.
    always_comb begin
        opc            = insn[6:0];
        f3             = insn[14:12];
        hi12           = insn[31:20];
        info.is_auipc  = (opc == 7'b0010111);
        info.is_jalr   = (opc == 7'b1100111) && (f3 == 3'b000);
        info.is_ld     = (opc == 7'b0000011) && (f3 == 3'b011);
        info.is_slli32 = (opc == 7'b0010011) && (f3 == 3'b001) && (hi12 == 12'h020);
        info.is_srli32 = (opc == 7'b0010011) && (f3 == 3'b101) && (hi12 == 12'h020);
        info.is_addiw  = (opc == 7'b0011011) && (f3 == 3'b000);
        info.rd        = insn[11:7];
        info.rs1       = insn[19:15];
        info.imm12     = hi12;
        info.imm20     = insn[31:12];
    end

endmodule

// File: rtl/fuse_match.sv
// Combinational pattern matcher over the three-slot window. Picks the
// longest matching idiom (three-slot add form first), builds the merged
// immediates, link value, secondary write and push hint.
// Assumes slot i+1 directly follows slot i in program order.
module fuse_match
    import fuse_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int ILEN = 32,
    parameter int BW   = 4
) (
    input  slot_info_t [NSLOT-1:0] info,
    input  logic [NSLOT-1:0]       valid,
    input  logic [NSLOT-1:0]       half,
    input  logic [ILEN-1:0]        insn0,
    input  logic [XLEN-1:0]        pc0,
    output fuse_kind_e             kind,
    output logic [1:0]             count,
    output logic [BW-1:0]          bytes,
    output logic [4:0]             rd,
    output logic [4:0]             src,
    output logic [XLEN-1:0]        target,
    output logic [XLEN-1:0]        link,
    output logic [XLEN-1:0]        imm,
    output logic                   tmp_we,
    output logic [4:0]             tmp_rd,
    output logic [XLEN-1:0]        tmp_val,
    output logic                   push,
    output logic [ILEN-1:0]        insn_pass
);

    function automatic logic [XLEN-1:0] sx12(input logic [11:0] v);
        return {{(XLEN-12){v[11]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] up20(input logic [19:0] v);
        return {{(XLEN-32){v[19]}}, v, 12'b0};
    endfunction

    function automatic logic is_zext(input slot_info_t a, input slot_info_t b);
        return a.is_slli32 && (a.rd == a.rs1) && (a.rd != 5'd0) &&
               b.is_srli32 && (b.rd == a.rd) && (b.rs1 == a.rd);
    endfunction

    logic [BW-1:0]   len_b [NSLOT];
    logic [XLEN-1:0] pc1, hi, sum;
    logic            m_call, m_tail, m_pcld, m_zext, m_addwz;
    logic [4:0]      x;

    // Per-slot byte lengths from the origin flag.
    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            len_b[i] = half[i] ? BW'(2) : BW'(4);
        end
    end

    // Pattern conditions over the window.
    always_comb begin
        x       = info[0].rd;
        m_call  = valid[0] && valid[1] && info[0].is_auipc && (x != 5'd0) &&
                  info[1].is_jalr && (info[1].rs1 == x) && (info[1].rd == x);
        m_tail  = valid[0] && valid[1] && info[0].is_auipc && (x != 5'd0) &&
                  info[1].is_jalr && (info[1].rs1 == x) && (info[1].rd == 5'd0);
        m_pcld  = valid[0] && valid[1] && info[0].is_auipc && (x != 5'd0) &&
                  info[1].is_ld && (info[1].rs1 == x);
        m_zext  = valid[0] && valid[1] && is_zext(info[0], info[1]);
        m_addwz = (&valid) && info[0].is_addiw && (info[0].rd == info[0].rs1) &&
                  (x != 5'd0) && is_zext(info[1], info[2]) && (info[1].rd == x);
    end

    // Merge the selected idiom into one micro-op, longest match first.
    always_comb begin
        pc1       = pc0 + XLEN'(len_b[0]);
        hi        = pc0 + up20(info[0].imm20);
        sum       = hi + sx12(info[1].imm12);
        kind      = K_SINGLE;
        count     = 2'd1;
        bytes     = len_b[0];
        rd        = info[0].rd;
        src       = info[0].rs1;
        target    = '0;
        link      = '0;
        imm       = '0;
        tmp_we    = 1'b0;
        tmp_rd    = 5'd0;
        tmp_val   = '0;
        push      = 1'b0;
        insn_pass = insn0;
        if (m_addwz) begin
            kind      = K_ADDWZ;
            count     = 2'd3;
            bytes     = len_b[0] + len_b[1] + len_b[2];
            imm       = sx12(info[0].imm12);
            insn_pass = '0;
        end else if (m_call || m_tail) begin
            kind      = m_call ? K_CALL : K_TAIL;
            count     = 2'd2;
            bytes     = len_b[0] + len_b[1];
            rd        = info[1].rd;
            src       = x;
            target    = {sum[XLEN-1:1], 1'b0};
            link      = pc1 + XLEN'(len_b[1]);
            tmp_we    = m_tail;
            tmp_rd    = m_tail ? x : 5'd0;
            tmp_val   = m_tail ? hi : '0;
            push      = m_call && ((x == 5'd1) || (x == 5'd5));
            insn_pass = '0;
        end else if (m_pcld) begin
            kind      = K_PCLD;
            count     = 2'd2;
            bytes     = len_b[0] + len_b[1];
            rd        = info[1].rd;
            src       = x;
            target    = sum;
            tmp_we    = (info[1].rd != x);
            tmp_rd    = (info[1].rd != x) ? x : 5'd0;
            tmp_val   = (info[1].rd != x) ? hi : '0;
            insn_pass = '0;
        end else if (m_zext) begin
            kind      = K_ZEXT;
            count     = 2'd2;
            bytes     = len_b[0] + len_b[1];
            insn_pass = '0;
        end
    end

endmodule

// File: rtl/fuse_unit.sv
// Top of the fusion detector: decodes the three window slots, matches
// idioms and registers the resulting micro-op (one cycle latency).
// Assumes synchronous active-low reset and a window that is already
// aligned to instruction boundaries with slot 0 at in_pc.
module fuse_unit
    import fuse_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int ILEN = 32,
    localparam int BW  = $clog2(4*NSLOT + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSLOT-1:0]      in_valid,
    input  logic [NSLOT-1:0]      in_half,
    input  logic [NSLOT*ILEN-1:0] in_insn,
    input  logic [XLEN-1:0]       in_pc,
    output logic                  uop_valid,
    output logic [2:0]            uop_kind,
    output logic [1:0]            uop_count,
    output logic [BW-1:0]         uop_bytes,
    output logic [4:0]            uop_rd,
    output logic [4:0]            uop_src,
    output logic [XLEN-1:0]       uop_target,
    output logic [XLEN-1:0]       uop_link,
    output logic [XLEN-1:0]       uop_imm,
    output logic                  uop_tmp_we,
    output logic [4:0]            uop_tmp_rd,
    output logic [XLEN-1:0]       uop_tmp_val,
    output logic                  uop_ras_push,
    output logic [ILEN-1:0]       uop_insn
);

    slot_info_t [NSLOT-1:0] info;
    fuse_kind_e             n_kind;
    logic [1:0]             n_count;
    logic [BW-1:0]          n_bytes;
    logic [4:0]             n_rd, n_src, n_tmp_rd;
    logic [XLEN-1:0]        n_target, n_link, n_imm, n_tmp_val;
    logic                   n_tmp_we, n_push;
    logic [ILEN-1:0]        n_insn;

    for (genvar g = 0; g < NSLOT; g++) begin : g_dec
        fuse_slot_dec #(.ILEN(ILEN)) u_dec (
            .insn (in_insn[g*ILEN +: ILEN]),
            .info (info[g])
        );
    end

    fuse_match #(.XLEN(XLEN), .ILEN(ILEN), .BW(BW)) u_match (
        .info      (info),
        .valid     (in_valid),
        .half      (in_half),
        .insn0     (in_insn[ILEN-1:0]),
        .pc0       (in_pc),
        .kind      (n_kind),
        .count     (n_count),
        .bytes     (n_bytes),
        .rd        (n_rd),
        .src       (n_src),
        .target    (n_target),
        .link      (n_link),
        .imm       (n_imm),
        .tmp_we    (n_tmp_we),
        .tmp_rd    (n_tmp_rd),
        .tmp_val   (n_tmp_val),
        .push      (n_push),
        .insn_pass (n_insn)
    );

    // Output register: capture the micro-op for the slot 0 instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uop_valid    <= 1'b0;
            uop_kind     <= 3'd0;
            uop_count    <= 2'd0;
            uop_bytes    <= '0;
            uop_rd       <= 5'd0;
            uop_src      <= 5'd0;
            uop_target   <= '0;
            uop_link     <= '0;
            uop_imm      <= '0;
            uop_tmp_we   <= 1'b0;
            uop_tmp_rd   <= 5'd0;
            uop_tmp_val  <= '0;
            uop_ras_push <= 1'b0;
            uop_insn     <= '0;
        end else begin
            uop_valid    <= in_valid[0];
            uop_kind     <= n_kind;
            uop_count    <= n_count;
            uop_bytes    <= n_bytes;
            uop_rd       <= n_rd;
            uop_src      <= n_src;
            uop_target   <= n_target;
            uop_link     <= n_link;
            uop_imm      <= n_imm;
            uop_tmp_we   <= in_valid[0] && n_tmp_we;
            uop_tmp_rd   <= n_tmp_rd;
            uop_tmp_val  <= n_tmp_val;
            uop_ras_push <= in_valid[0] && n_push;
            uop_insn     <= n_insn;
        end
    end

endmodule

// File: rtl/fuse_unit_chk.sv
// Property checker for fuse_unit, bound to every instance of it.
// Assumes in_valid is known from reset onward.
module fuse_unit_chk
    import fuse_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int BW  = $clog2(4*NSLOT + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSLOT-1:0] in_valid,
    input logic            uop_valid,
    input logic [2:0]      uop_kind,
    input logic [1:0]      uop_count,
    input logic [BW-1:0]   uop_bytes,
    input logic [4:0]      uop_rd,
    input logic [XLEN-1:0] uop_target,
    input logic            uop_tmp_we,
    input logic [4:0]      uop_tmp_rd,
    input logic            uop_ras_push
);

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (uop_valid == $past(in_valid[0])));

    p_single_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_kind == K_SINGLE) |-> (uop_count == 2'd1 && !uop_tmp_we && !uop_ras_push));

    p_pair_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_kind inside {K_CALL, K_TAIL, K_PCLD, K_ZEXT}) |-> (uop_count == 2'd2));

    p_triple_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_kind == K_ADDWZ) |-> (uop_count == 2'd3));

    p_push_only_call_r4: assert property (@(posedge clk) disable iff (!rst_n)
        uop_ras_push |-> (uop_valid && uop_kind == K_CALL && (uop_rd == 5'd1 || uop_rd == 5'd5)));

    p_tail_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_kind == K_TAIL) |-> (uop_rd == 5'd0 && uop_tmp_we && uop_tmp_rd != 5'd0));

    p_jump_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_kind inside {K_CALL, K_TAIL}) |-> (uop_target[0] == 1'b0));

    p_bytes_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> ((uop_bytes >= BW'(2) * BW'(uop_count)) && (uop_bytes <= BW'(4) * BW'(uop_count))));

endmodule

bind fuse_unit fuse_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_fuse_unit.sv
module sim_fuse_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  in_valid = '0;
    logic [2:0]  in_half = '0;
    logic [95:0] in_insn = '0;
    logic [63:0] in_pc = '0;
    logic        uop_valid, uop_tmp_we, uop_ras_push;
    logic [2:0]  uop_kind;
    logic [1:0]  uop_count;
    logic [3:0]  uop_bytes;
    logic [4:0]  uop_rd, uop_src, uop_tmp_rd;
    logic [63:0] uop_target, uop_link, uop_imm, uop_tmp_val;
    logic [31:0] uop_insn;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    fuse_unit u0 (.*);

    // Instruction encoders
    function automatic logic [31:0] e_auipc(logic [4:0] rd, logic [19:0] i);
        return {i, rd, 7'b0010111};
    endfunction
    function automatic logic [31:0] e_jalr(logic [4:0] rd, logic [4:0] rs, logic [11:0] i);
        return {i, rs, 3'b000, rd, 7'b1100111};
    endfunction
    function automatic logic [31:0] e_ld(logic [4:0] rd, logic [4:0] rs, logic [11:0] i);
        return {i, rs, 3'b011, rd, 7'b0000011};
    endfunction
    function automatic logic [31:0] e_sh(logic [2:0] f3, logic [5:0] hi, logic [4:0] rd, logic [4:0] rs, logic [5:0] sh);
        return {hi, sh, rs, f3, rd, 7'b0010011};
    endfunction
    function automatic logic [31:0] e_addiw(logic [4:0] rd, logic [4:0] rs, logic [11:0] i);
        return {i, rs, 3'b000, rd, 7'b0011011};
    endfunction

    // Reference one-at-a-time semantics
    function automatic logic [63:0] r_auipc(logic [63:0] pc, logic [19:0] i);
        return pc + {{32{i[19]}}, i, 12'b0};
    endfunction
    function automatic logic [63:0] r_sx(logic [11:0] i);
        return {{52{i[11]}}, i};
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(logic [2:0] v, logic [2:0] h, logic [31:0] a, logic [31:0] b, logic [31:0] c, logic [63:0] pc);
        @(negedge clk);
        in_valid = v; in_half = h; in_insn = {c, b, a}; in_pc = pc;
        @(negedge clk);
    endtask

    task automatic chk_shape(string req, int kind, int cnt, int byt);
        chk(req, "valid", 64'(uop_valid), 64'd1);
        chk(req, "kind", 64'(uop_kind), 64'(kind));
        chk(req, "count", 64'(uop_count), 64'(cnt));
        chk(req, "bytes", 64'(uop_bytes), 64'(byt));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", 64'(uop_valid), 64'd0);
        in_valid = 3'b111; in_insn = {3{e_addiw(5'd3, 5'd3, 12'd1)}};
        @(negedge clk);
        chk("R1", "valid in reset w/ input", 64'(uop_valid), 64'd0);
        in_valid = '0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid after release", 64'(uop_valid), 64'd0);
    endtask

    task automatic t_call(logic [4:0] x, logic [19:0] hi, logic [11:0] lo, logic jhalf, logic exp_push);
        logic [63:0] pc = 64'h0000_0000_8000_1000;
        logic [63:0] t = r_auipc(pc, hi) + r_sx(lo);
        apply(3'b011, {1'b0, jhalf, 1'b0}, e_auipc(x, hi), e_jalr(x, x, lo), 32'h0, pc);
        chk_shape("R3", 1, 2, jhalf ? 6 : 8);
        chk("R3", "target", uop_target, {t[63:1], 1'b0});
        chk("R9", "link", uop_link, pc + 64'd4 + (jhalf ? 64'd2 : 64'd4));
        chk("R3", "rd", 64'(uop_rd), 64'(x));
        chk("R3", "tmp_we", 64'(uop_tmp_we), 64'd0);
        chk("R4", "push", 64'(uop_ras_push), 64'(exp_push));
    endtask

    task automatic t_tail();
        logic [63:0] pc = 64'h0000_0010_0000_2004;
        logic [63:0] h = r_auipc(pc, 20'hFFFFF);
        apply(3'b111, 3'b000, e_auipc(5'd6, 20'hFFFFF), e_jalr(5'd0, 5'd6, 12'h7FF), e_addiw(5'd1, 5'd1, 12'd0), pc);
        chk_shape("R5", 2, 2, 8);
        chk("R5", "target", uop_target, (h + 64'h7FF) & ~64'd1);
        chk("R5", "rd", 64'(uop_rd), 64'd0);
        chk("R5", "tmp_we", 64'(uop_tmp_we), 64'd1);
        chk("R5", "tmp_rd", 64'(uop_tmp_rd), 64'd6);
        chk("R5", "tmp_val", uop_tmp_val, h);
        chk("R4", "no push on tail", 64'(uop_ras_push), 64'd0);
    endtask

    task automatic t_pcld(logic [4:0] y);
        logic [63:0] pc = 64'h0000_0000_0001_aec0;
        logic [63:0] h = r_auipc(pc, 20'h00018);
        apply(3'b011, 3'b000, e_auipc(5'd10, 20'h00018), e_ld(y, 5'd10, 12'h881), 32'h0, pc);
        chk_shape("R6", 3, 2, 8);
        chk("R6", "address", uop_target, h + r_sx(12'h881));
        chk("R6", "rd", 64'(uop_rd), 64'(y));
        chk("R6", "tmp_we", 64'(uop_tmp_we), 64'(y != 5'd10));
        if (y != 5'd10) begin
            chk("R6", "tmp_rd", 64'(uop_tmp_rd), 64'd10);
            chk("R6", "tmp_val", uop_tmp_val, h);
        end
    endtask

    task automatic t_zext();
        apply(3'b011, 3'b011, e_sh(3'b001, 6'd0, 5'd11, 5'd11, 6'd32), e_sh(3'b101, 6'd0, 5'd11, 5'd11, 6'd32), 32'h0, 64'h100);
        chk_shape("R7", 4, 2, 4);
        chk("R7", "rd", 64'(uop_rd), 64'd11);
        chk("R7", "src", 64'(uop_src), 64'd11);
    endtask

    task automatic t_addwz();
        apply(3'b111, 3'b110, e_addiw(5'd11, 5'd11, 12'hFFF), e_sh(3'b001, 6'd0, 5'd11, 5'd11, 6'd32),
              e_sh(3'b101, 6'd0, 5'd11, 5'd11, 6'd32), 64'h10994);
        chk_shape("R8", 5, 3, 8);
        chk("R8", "imm", uop_imm, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R8", "rd", 64'(uop_rd), 64'd11);
        // Last slot invalid: falls back to single ADDIW (R2)
        apply(3'b011, 3'b000, e_addiw(5'd11, 5'd11, 12'd5), e_sh(3'b001, 6'd0, 5'd11, 5'd11, 6'd32),
              e_sh(3'b101, 6'd0, 5'd11, 5'd11, 6'd32), 64'h200);
        chk_shape("R2", 0, 1, 4);
        chk("R2", "insn", 64'(uop_insn), 64'(e_addiw(5'd11, 5'd11, 12'd5)));
    endtask

    task automatic single(string req, logic [2:0] h, logic [31:0] a, logic [31:0] b, logic [31:0] c);
        apply(3'b111, h, a, b, c, 64'h4000);
        chk_shape(req, 0, 1, h[0] ? 2 : 4);
        chk(req, "insn", 64'(uop_insn), 64'(a));
        chk(req, "tmp_we", 64'(uop_tmp_we), 64'd0);
        chk(req, "push", 64'(uop_ras_push), 64'd0);
    endtask

    task automatic t_reject();
        single("R10", 3'b000, e_auipc(5'd1, 20'h1), e_jalr(5'd1, 5'd2, 12'd0), 32'h0);
        single("R10", 3'b000, e_auipc(5'd5, 20'h1), e_jalr(5'd1, 5'd5, 12'd0), 32'h0);
        single("R10", 3'b000, e_auipc(5'd0, 20'h1), e_jalr(5'd0, 5'd0, 12'd0), 32'h0);
        single("R10", 3'b000, e_auipc(5'd7, 20'h1), e_ld(5'd7, 5'd8, 12'd0), 32'h0);
        single("R10", 3'b001, e_sh(3'b001, 6'd0, 5'd9, 5'd9, 6'd31), e_sh(3'b101, 6'd0, 5'd9, 5'd9, 6'd31), 32'h0);
        single("R10", 3'b000, e_sh(3'b001, 6'd0, 5'd9, 5'd9, 6'd32), e_sh(3'b101, 6'h10, 5'd9, 5'd9, 6'd32), 32'h0);
        single("R10", 3'b000, e_sh(3'b001, 6'd0, 5'd9, 5'd9, 6'd32), e_sh(3'b101, 6'd0, 5'd8, 5'd9, 6'd32), 32'h0);
        single("R10", 3'b000, e_addiw(5'd9, 5'd8, 12'd1), e_sh(3'b001, 6'd0, 5'd9, 5'd9, 6'd32), e_sh(3'b101, 6'd0, 5'd9, 5'd9, 6'd32));
    endtask

    task automatic t_valid();
        apply(3'b001, 3'b000, e_auipc(5'd1, 20'h2), e_jalr(5'd1, 5'd1, 12'd0), 32'h0, 64'h8000);
        chk_shape("R2", 0, 1, 4);
        apply(3'b110, 3'b000, e_auipc(5'd1, 20'h2), e_jalr(5'd1, 5'd1, 12'd0), 32'h0, 64'h8000);
        chk("R2", "valid slot0 off", 64'(uop_valid), 64'd0);
        chk("R4", "no push when idle", 64'(uop_ras_push), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_call(5'd1, 20'h00182, 12'hF5C, 1'b0, 1'b1);
        t_call(5'd5, 20'hFFFF0, 12'h7FF, 1'b0, 1'b1);
        t_call(5'd10, 20'h00003, 12'h001, 1'b0, 1'b0);
        t_call(5'd1, 20'h00010, 12'h000, 1'b1, 1'b1);
        t_tail();
        t_pcld(5'd10);
        t_pcld(5'd11);
        t_zext();
        t_addwz();
        t_reject();
        t_valid();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule